// File: doc/BRIEF.md
# Two-Bank Flow-Through Burst SRAM

This block is a synthesizable behavioural model of a synchronous burst static RAM. The memory is split into two banks, and each bank has its own active-low enable. A word is 72 bits wide: eight data bytes, each paired with one parity bit. Addresses, strobes and write controls are captured on the rising clock edge. The block is flow-through, so the word at a newly captured address reaches the output after that same edge, with no extra pipeline stage. The output enable is asynchronous and acts directly on the output.

A new access starts from one of two address-status strobes. The processor strobe has the higher priority and always starts a read. The controller strobe starts a read or a write, depending on the write controls. When neither strobe is asserted, an active access either steps through a linear burst that wraps within a group of four words, or it stays on its current address. A global write stores the whole word. Otherwise, individual bytes, each with its parity bit, can be written when byte-write mode is enabled. Holding the controller strobe low while the other strobe and advance stay high gives plain single-word synchronous reads and writes. If both banks are enabled at the same time, the block reports it and stores nothing.

Top module: `sbsram_2bank`

## Requirements
- R1: After reset, `dout_en` and `illegal` are 0.
- R2: `adsp_n` low with exactly one bank enabled captures `addr` and starts a read, whatever the write inputs and `adsc_n` are. It stores nothing, and the addressed word appears on `dout` right after that edge.
- R3: With `adsp_n` high, `adsc_n` low and exactly one bank enabled, `addr` is captured. The cycle is a write when a write is requested (see R7, R8), and a read otherwise.
- R4: With `adsc_n` low and no bank enabled, the block is deselected: `dout_en` is 0 from the next edge on, until a new access starts.
- R5: With both strobes high and `adv_n` low, an active access moves to the next address. Only the two low address bits count up, wrapping 3 to 0. Reads and writes both follow this rule.
- R6: With both strobes high and `adv_n` high, the current address is reused. A write in this case overwrites the same word again.
- R7: With `gw_n` low, all 72 bits are written, whatever `bwe_n` and `bw_n` are.
- R8: With `gw_n` high and `bwe_n` low, each lane k whose `bw_n[k]` is 0 is written. Lane k is data bits 8k+7..8k together with parity bit 64+k. All other lanes keep their contents.
- R9: With `gw_n` high and either `bwe_n` high or `bw_n` all ones, nothing is written, and the cycle reads.
- R10: `dout_en` is 1 only while a read access is active and `oe_n` is low. It follows `oe_n` without waiting for a clock edge.
- R11: Either strobe low with both banks enabled (`bank_en_n` = 00) deselects the block and stores nothing. `illegal` is 1 for the following cycle only.
- R12: Bank 0 is enabled by `bank_en_n` = 10 and bank 1 by `bank_en_n` = 01. The two banks hold independent contents at the same address.
- R13: `dout` is all zeros whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` are captured on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address |
| adsp_n | input | 1 | Processor address strobe, active low, read only, highest priority |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high holds the address |
| bank_en_n | input | 2 | Active-low bank enables; bit 0 enables bank 0 |
| gw_n | input | 1 | Global write of the whole word, active low |
| bwe_n | input | 1 | Byte-write mode enable, active low |
| bw_n | input | LANES | Per-lane byte write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*(BYTE_W+1) | Write word: data bytes, then parity bits at the top |
| dout | output | LANES*(BYTE_W+1) | Read word, zero when not driven |
| dout_en | output | 1 | Output drive enable |
| illegal | output | 1 | Both banks were enabled with a strobe in the previous cycle |

## Verification
First, every word in both banks is filled with a distinct full-word pattern and read back. This tells addressing faults apart from bank-crossing faults. A sweep of byte-enable masks with new data shows whether each data byte and its parity bit follow their own enable, and whether they stay in the right lane. Read and write bursts that start on an unaligned address, with holds in between, separate a correct wrap in the low bits from a carry into the upper bits, and a hold from a step. Single-cycle patterns then try the corner cases one at a time: a processor strobe together with write controls, byte mode with no lane selected, a global write against byte enables, both banks enabled, the output enable toggled between clock edges, and a deselect followed by advance.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
    localparam int NBANK = 2;

    typedef enum logic [2:0] {
        CYC_NONE,
        CYC_DESEL,
        CYC_START,
        CYC_NEXT,
        CYC_HOLD
    } cyc_e;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic [NBANK-1:0] bank_en_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             sel_q,
    output cyc_e             kind,
    output logic             bank_idx,
    output logic [LANES-1:0] wr_mask,
    output logic             clash
);
    logic [1:0]       n_on;
    logic             lone;
    logic             many;
    logic [LANES-1:0] mask_c;

    always_comb begin
        n_on   = 2'($countones(~bank_en_n));
        lone   = (n_on == 2'd1);
        many   = (n_on > 2'd1);
        // global write wins over byte mode
        mask_c = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
        // index of the enabled bank: bit 0 low means bank 0
        bank_idx = bank_en_n[0];
        kind    = CYC_NONE;
        wr_mask = '0;
        clash   = 1'b0;
        if (!adsp_n && lone) begin
            kind = CYC_START;          // read only, write inputs ignored
        end else if (!adsc_n && lone) begin
            kind    = CYC_START;
            wr_mask = mask_c;
        end else if ((!adsp_n || !adsc_n) && many) begin
            kind  = CYC_DESEL;
            clash = 1'b1;
        end else if (!adsc_n) begin
            kind = CYC_DESEL;
        end else if (sel_q) begin
            kind    = adv_n ? CYC_HOLD : CYC_NEXT;
            wr_mask = mask_c;
        end
    end
endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int BURST_W = 2
) (
    input  cyc_e              kind,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] use_addr
);
    logic [ADDR_W-1:0] step_addr;

    generate
        if (BURST_W == 0) begin : g_flat
            assign step_addr = cur_addr;
        end else if (BURST_W >= ADDR_W) begin : g_full
            assign step_addr = cur_addr + ADDR_W'(1);
        end else begin : g_wrap
            logic [BURST_W-1:0] low_n;
            assign low_n     = cur_addr[BURST_W-1:0] + BURST_W'(1);
            assign step_addr = {cur_addr[ADDR_W-1:BURST_W], low_n};
        end
    endgenerate

    always_comb begin
        case (kind)
            CYC_START: use_addr = ext_addr;
            CYC_NEXT:  use_addr = step_addr;
            default:   use_addr = cur_addr;
        endcase
    end
endmodule

// File: rtl/sbsram_bank.sv
module sbsram_bank #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 8,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_we[l]) begin
                cells[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        // flow-through: asynchronous read of the registered address
        assign rdata[l*LANE_W +: LANE_W] = cells[raddr];
    end
endmodule

// File: rtl/sbsram_2bank.sv
module sbsram_2bank
    import sbsram_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int BURST_W = 2,
    parameter int BYTE_W  = 8,
    parameter int LANES   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          adsp_n,
    input  logic                          adsc_n,
    input  logic                          adv_n,
    input  logic [1:0]                    bank_en_n,
    input  logic                          gw_n,
    input  logic                          bwe_n,
    input  logic [LANES-1:0]              bw_n,
    input  logic                          oe_n,
    input  logic [LANES*(BYTE_W+1)-1:0]   din,
    output logic [LANES*(BYTE_W+1)-1:0]   dout,
    output logic                          dout_en,
    output logic                          illegal
);
    localparam int LANE_W = BYTE_W + 1;
    localparam int WORD_W = LANES * LANE_W;
    localparam int DATA_W = LANES * BYTE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              bank;
        logic              sel;
        logic              rd;
        logic              bad;
    } state_t;

    state_t st_d, st_q;

    cyc_e              kind;
    logic              bank_idx;
    logic [LANES-1:0]  wr_mask;
    logic              clash;
    logic [ADDR_W-1:0] use_addr;
    logic              wr_bank;
    logic              any_wr;
    logic [WORD_W-1:0] lane_in;
    logic [WORD_W-1:0] lane_rd;
    logic [WORD_W-1:0] word_rd;
    logic [WORD_W-1:0] bank_rd [NBANK];

    sbsram_decode #(.LANES(LANES)) u_decode (
        .adsp_n    (adsp_n),
        .adsc_n    (adsc_n),
        .adv_n     (adv_n),
        .bank_en_n (bank_en_n),
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bw_n      (bw_n),
        .sel_q     (st_q.sel),
        .kind      (kind),
        .bank_idx  (bank_idx),
        .wr_mask   (wr_mask),
        .clash     (clash)
    );

    sbsram_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
        .kind     (kind),
        .ext_addr (addr),
        .cur_addr (st_q.addr),
        .use_addr (use_addr)
    );

    // lane k = {parity bit k, data byte k}
    for (genvar k = 0; k < LANES; k++) begin : g_pack
        assign lane_in[k*LANE_W +: LANE_W] = {din[DATA_W+k], din[k*BYTE_W +: BYTE_W]};
        assign word_rd[DATA_W+k]            = lane_rd[k*LANE_W+BYTE_W];
        assign word_rd[k*BYTE_W +: BYTE_W]  = lane_rd[k*LANE_W +: BYTE_W];
    end

    assign any_wr  = |wr_mask;
    assign wr_bank = (kind == CYC_START) ? bank_idx : st_q.bank;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sbsram_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank (
            .clk     (clk),
            .we      (any_wr && (wr_bank == 1'(b))),
            .lane_we (wr_mask),
            .waddr   (use_addr),
            .wdata   (lane_in),
            .raddr   (st_q.addr),
            .rdata   (bank_rd[b])
        );
    end

    assign lane_rd = bank_rd[st_q.bank];

    always_comb begin
        st_d     = st_q;
        st_d.bad = clash;
        case (kind)
            CYC_DESEL: begin
                st_d.sel = 1'b0;
                st_d.rd  = 1'b0;
            end
            CYC_START: begin
                st_d.addr = use_addr;
                st_d.bank = bank_idx;
                st_d.sel  = 1'b1;
                st_d.rd   = !any_wr;
            end
            CYC_NEXT, CYC_HOLD: begin
                st_d.addr = use_addr;
                st_d.rd   = !any_wr;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_en = st_q.sel && st_q.rd && !oe_n;
    assign dout    = dout_en ? word_rd : '0;
    assign illegal = st_q.bad;
endmodule

// File: rtl/sbsram_2bank_chk.sv
module sbsram_2bank_chk #(
    parameter int DW = 72
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adsp_n,
    input logic          adsc_n,
    input logic [1:0]    bank_en_n,
    input logic          oe_n,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic          illegal
);
    a_r10_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    a_r13_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    a_r4_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsc_n && bank_en_n == 2'b11) |=> !dout_en);

    a_r11_clash_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((!adsp_n || !adsc_n) && bank_en_n == 2'b00) |=> (illegal && !dout_en));

    a_r11_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
        !((!adsp_n || !adsc_n) && bank_en_n == 2'b00) |=> !illegal);

    a_r2_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && $countones(~bank_en_n) == 1 && !oe_n) |=> (dout_en || oe_n));
endmodule

bind sbsram_2bank sbsram_2bank_chk #(.DW(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adsp_n    (adsp_n),
    .adsc_n    (adsc_n),
    .bank_en_n (bank_en_n),
    .oe_n      (oe_n),
    .dout      (dout),
    .dout_en   (dout_en),
    .illegal   (illegal)
);

// File: tb/test_sbsram_2bank.sv
`timescale 1ns/1ps
module test_sbsram_2bank;
    localparam int AW = 4;
    localparam int LN = 8;
    localparam int WW = 72;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n;
    logic [1:0]    bank_en_n;
    logic [LN-1:0] bw_n;
    logic [WW-1:0] din, dout;
    logic          dout_en, illegal;

    logic [WW-1:0] refm [2][16];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sbsram_2bank i_sbsram_2bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .bank_en_n(bank_en_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en),
        .illegal(illegal)
    );

    task automatic chk(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] pat(int b, int a, int s);
        logic [63:0] lo;
        logic [7:0]  hi;
        lo = 64'h9E37_79B9_7F4A_7C15 * 64'(a + 16*b + 32*s + 1);
        hi = 8'(a*29 + b*101 + s*7 + 3);
        return {hi, lo};
    endfunction

    function automatic logic [WW-1:0] merge(logic [WW-1:0] old, logic [WW-1:0] d, logic [LN-1:0] m);
        logic [WW-1:0] r = old;
        for (int k = 0; k < LN; k++) begin
            if (m[k]) begin
                r[8*k +: 8] = d[8*k +: 8];
                r[64+k]     = d[64+k];
            end
        end
        return r;
    endfunction

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] a);
        return {a[AW-1:2], 2'(a[1:0] + 2'd1)};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        adsp_n = 1; adsc_n = 1; adv_n = 1; bank_en_n = 2'b11;
        gw_n = 1; bwe_n = 1; bw_n = '1; din = '0;
    endtask

    task automatic ctl_op(int b, int a, logic g, logic be, logic [LN-1:0] bwn, logic [WW-1:0] d);
        quiet();
        adsc_n = 0; bank_en_n = (b == 0) ? 2'b10 : 2'b01; addr = AW'(a);
        gw_n = g; bwe_n = be; bw_n = bwn; din = d;
        tick();
        quiet();
    endtask

    task automatic rd_chk(string req, int b, int a);
        ctl_op(b, a, 1, 1, '1, '0);
        chk({req, " en"}, WW'(dout_en), WW'(1));
        chk(req, dout, refm[b][a]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        logic [LN-1:0] m;
        quiet(); oe_n = 0; addr = '0; rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 dout_en", WW'(dout_en), WW'(0));
        chk("R1 illegal", WW'(illegal), WW'(0));
        rst_n = 1;

        // R3 R7 R12: full-word fill of both banks, then readback
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 16; i++) begin
                ctl_op(b, i, 0, 1, '1, pat(b, i, 0));
                refm[b][i] = pat(b, i, 0);
                chk("R3 write not driven", WW'(dout_en), WW'(0));
            end
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 16; i++) rd_chk("R12 bank readback", b, i);

        // R8: byte mask sweep on bank 0 word 3
        for (int s = 1; s <= 20; s++) begin
            m = (s <= 8) ? LN'(1 << (s - 1)) : LN'(s * 37);
            ctl_op(0, 3, 1, 0, ~m, pat(0, 3, s));
            refm[0][3] = merge(refm[0][3], pat(0, 3, s), m);
            rd_chk("R8 byte lanes", 0, 3);
        end

        // R9: byte mode off with lanes selected, or byte mode with no lane
        ctl_op(1, 5, 1, 1, 8'h00, pat(1, 5, 9));
        chk("R9 reads", dout, refm[1][5]);
        ctl_op(1, 5, 1, 0, 8'hFF, pat(1, 5, 10));
        chk("R9 reads no lane", dout, refm[1][5]);
        rd_chk("R9 unchanged", 1, 5);

        // R7: global write overrides byte enables
        ctl_op(1, 12, 0, 0, 8'hFE, pat(1, 12, 4));
        refm[1][12] = pat(1, 12, 4);
        rd_chk("R7 global", 1, 12);

        // R2: processor strobe with write controls reads, flow-through
        quiet(); adsp_n = 0; adsc_n = 0; bank_en_n = 2'b01; addr = 4'd6;
        gw_n = 0; bwe_n = 0; bw_n = '0; din = pat(1, 6, 7);
        tick();
        chk("R2 en", WW'(dout_en), WW'(1));
        chk("R2 data", dout, refm[1][6]);
        // R5 R6: burst read 6 -> 7 -> 4, hold 4, -> 5 -> 6
        quiet(); adv_n = 0; a = 4'd6;
        a = nxt(a); tick(); chk("R5 burst read", dout, refm[1][a]);
        a = nxt(a); tick(); chk("R5 burst wrap", dout, refm[1][a]);
        adv_n = 1;  tick(); chk("R6 hold read", dout, refm[1][a]);
        adv_n = 0;
        a = nxt(a); tick(); chk("R5 burst read", dout, refm[1][a]);
        a = nxt(a); tick(); chk("R5 burst read", dout, refm[1][a]);
        rd_chk("R2 no write", 1, 6);

        // R5 R6: burst write from 9
        ctl_op(0, 9, 0, 1, '1, pat(0, 9, 11));
        refm[0][9] = pat(0, 9, 11);
        a = 4'd9;
        adv_n = 0; gw_n = 0;
        for (int s = 12; s < 14; s++) begin
            a = nxt(a); din = pat(0, a, s); refm[0][a] = din; tick();
            chk("R5 burst write not driven", WW'(dout_en), WW'(0));
        end
        adv_n = 1; din = pat(0, a, 14); refm[0][a] = din; tick();
        adv_n = 0; a = nxt(a); din = pat(0, a, 15); refm[0][a] = din; tick();
        gw_n = 1; bwe_n = 0; bw_n = 8'hF0;
        a = nxt(a); din = pat(0, a, 16); refm[0][a] = merge(refm[0][a], din, 8'h0F); tick();
        quiet();
        for (int i = 8; i < 12; i++) rd_chk("R6 R5 burst write result", 0, i);

        // R10: output enable high blocks, async release
        oe_n = 1;
        ctl_op(0, 2, 1, 1, '1, '0);
        chk("R10 oe high en", WW'(dout_en), WW'(0));
        chk("R13 zero", dout, '0);
        oe_n = 0; #0.5;
        chk("R10 async on", WW'(dout_en), WW'(1));
        chk("R10 async data", dout, refm[0][2]);
        oe_n = 1; #0.5;
        chk("R10 async off", WW'(dout_en), WW'(0));
        oe_n = 0;

        // R4: deselect, then advance stays deselected
        quiet(); adsc_n = 0; tick();
        chk("R4 deselect", WW'(dout_en), WW'(0));
        chk("R13 zero", dout, '0);
        quiet(); adv_n = 0; gw_n = 0; din = pat(0, 3, 40); tick();
        chk("R4 stays off", WW'(dout_en), WW'(0));
        quiet();

        // R11: both banks enabled
        quiet(); adsc_n = 0; bank_en_n = 2'b00; addr = 4'd2; gw_n = 0; din = pat(0, 2, 50);
        tick();
        chk("R11 flag", WW'(illegal), WW'(1));
        chk("R11 off", WW'(dout_en), WW'(0));
        quiet(); adsp_n = 0; bank_en_n = 2'b00; addr = 4'd1; tick();
        chk("R11 flag proc", WW'(illegal), WW'(1));
        quiet(); tick();
        chk("R11 flag clears", WW'(illegal), WW'(0));
        rd_chk("R11 bank0 intact", 0, 2);
        rd_chk("R11 bank1 intact", 1, 2);

        // final sweep over every word
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 16; i++) rd_chk("R12 final", b, i);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule